// File: doc/BRIEF.md
# Three-Channel Residue Number Adder

This block adds two small unsigned integers in residue form. Each 5-bit operand is first reduced modulo each member of the pairwise-coprime set {3, 5, 7}. The block then adds the two residues of each channel modulo that channel's modulus. The three channels work side by side. No carry or other information passes from one channel to another, so the critical path is set by a single 3-bit modular channel, not by a weighted binary carry chain.

One register stage separates the inputs from the outputs. When the input strobe is high at a rising clock edge, the three channel sums of the operands present at that edge are captured. The output valid flag is raised for the following cycle. The residue outputs hold their value until the next strobe. Converting residues back to binary is left to downstream logic.

Top module: `rns_adder3`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, out_valid is 0 and all three residue outputs are 0.
- R2: Each operand is converted to residues by reduction modulo 3, 5 and 7. Adding an operand X to zero yields (X mod 3, X mod 5, X mod 7); for example 13 gives (1,3,6) and 17 gives (2,2,3).
- R3: sum_p0 is 2 bits wide and equals (op_a + op_b) mod 3 for the operands strobed in the previous cycle.
- R4: sum_p1 is 3 bits wide and equals (op_a + op_b) mod 5 for the operands strobed in the previous cycle.
- R5: sum_p2 is 3 bits wide and equals (op_a + op_b) mod 7 for the operands strobed in the previous cycle.
- R6: out_valid is high in exactly the cycle after each cycle in which in_valid is high, and low otherwise.
- R7: While in_valid is low, changes on op_a and op_b have no effect, and the three residue outputs keep their last values.
- R8: Operands 13 and 17 produce the residue sum (0,0,2).
- R9: The largest operands, 31 and 31, produce (2,2,6). Zero and zero produce (0,0,0).
- R10: Every residue output always stays below its channel's modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 5 | First unsigned operand |
| op_b | input | 5 | Second unsigned operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| sum_p0 | output | 2 | Sum residue modulo 3 |
| sum_p1 | output | 3 | Sum residue modulo 5 |
| sum_p2 | output | 3 | Sum residue modulo 7 |

## Verification
The hardest case to reach is the one where a channel's two residues add to at least the modulus, so that the single conditional subtraction is needed. This case occurs for different operand pairs in each channel. The bench therefore walks all 1024 operand pairs back to back and compares each channel against a sum reduced in the bench. A second hard case is a change on the operands while the strobe is low. The bench drives new operands with the strobe held low for several cycles and then checks that the outputs did not move.

// File: rtl/rns_pkg.sv
package rns_pkg;
    localparam int unsigned OP_W    = 5;
    localparam int unsigned N_CHAN  = 3;
    localparam int unsigned MOD_0   = 3;
    localparam int unsigned MOD_1   = 5;
    localparam int unsigned MOD_2   = 7;
endpackage

// File: rtl/rns_reduce.sv
// Binary to residue: restoring reduction, one bit per step from the MSB.
module rns_reduce #(
    parameter int unsigned IN_W  = 5,
    parameter int unsigned MODV  = 7,
    parameter int unsigned OUT_W = 3
) (
    input  logic [IN_W-1:0]  bin_i,
    output logic [OUT_W-1:0] res_o
);
    localparam int unsigned RW = OUT_W + 1;
    localparam logic [RW-1:0] MODR = RW'(MODV);

    logic [RW-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = IN_W - 1; i >= 0; i--) begin
            acc = {acc[OUT_W-1:0], bin_i[i]};
            if (acc >= MODR) begin
                acc = acc - MODR;
            end
        end
        res_o = acc[OUT_W-1:0];
    end
endmodule

// File: rtl/rns_mod_add.sv
// Adds two residues already below MODV; one conditional subtraction.
module rns_mod_add #(
    parameter int unsigned MODV = 7,
    parameter int unsigned W    = 3
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] s_o
);
    localparam logic [W:0] MODR = (W + 1)'(MODV);

    logic [W:0] raw;

    always_comb begin
        raw = {1'b0, x_i} + {1'b0, y_i};
        if (raw >= MODR) begin
            raw = raw - MODR;
        end
        s_o = raw[W-1:0];
    end
endmodule

// File: rtl/rns_channel.sv
// One residue channel: forward conversion of both operands, then modular add.
module rns_channel #(
    parameter int unsigned IN_W = 5,
    parameter int unsigned MODV = 7,
    parameter int unsigned W    = 3
) (
    input  logic [IN_W-1:0] a_i,
    input  logic [IN_W-1:0] b_i,
    output logic [W-1:0]    sum_o
);
    logic [W-1:0] ra;
    logic [W-1:0] rb;

    rns_reduce #(.IN_W(IN_W), .MODV(MODV), .OUT_W(W)) u_red_a (
        .bin_i (a_i),
        .res_o (ra)
    );

    rns_reduce #(.IN_W(IN_W), .MODV(MODV), .OUT_W(W)) u_red_b (
        .bin_i (b_i),
        .res_o (rb)
    );

    rns_mod_add #(.MODV(MODV), .W(W)) u_add (
        .x_i (ra),
        .y_i (rb),
        .s_o (sum_o)
    );
endmodule

// File: rtl/rns_adder3.sv
module rns_adder3 #(
    parameter int unsigned OPW  = rns_pkg::OP_W,
    parameter int unsigned MOD0 = rns_pkg::MOD_0,
    parameter int unsigned MOD1 = rns_pkg::MOD_1,
    parameter int unsigned MOD2 = rns_pkg::MOD_2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [OPW-1:0]           op_a,
    input  logic [OPW-1:0]           op_b,
    output logic                     out_valid,
    output logic [$clog2(MOD0)-1:0]  sum_p0,
    output logic [$clog2(MOD1)-1:0]  sum_p1,
    output logic [$clog2(MOD2)-1:0]  sum_p2
);
    localparam int unsigned W0   = $clog2(MOD0);
    localparam int unsigned W1   = $clog2(MOD1);
    localparam int unsigned W2   = $clog2(MOD2);
    localparam int unsigned WMAX = (W0 > W1) ? ((W0 > W2) ? W0 : W2)
                                             : ((W1 > W2) ? W1 : W2);
    localparam int unsigned NCH  = rns_pkg::N_CHAN;

    typedef struct packed {
        logic          vld;
        logic [W0-1:0] r0;
        logic [W1-1:0] r1;
        logic [W2-1:0] r2;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [WMAX-1:0] ch_sum [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam int unsigned PM = (g == 0) ? MOD0 : (g == 1) ? MOD1 : MOD2;
        localparam int unsigned PW = $clog2(PM);
        logic [PW-1:0] s_loc;

        rns_channel #(.IN_W(OPW), .MODV(PM), .W(PW)) u_ch (
            .a_i   (op_a),
            .b_i   (op_b),
            .sum_o (s_loc)
        );

        assign ch_sum[g] = WMAX'(s_loc);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.r0 = ch_sum[0][W0-1:0];
            st_d.r1 = ch_sum[1][W1-1:0];
            st_d.r2 = ch_sum[2][W2-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign sum_p0    = st_q.r0;
    assign sum_p1    = st_q.r1;
    assign sum_p2    = st_q.r2;
endmodule

// File: rtl/rns_adder3_chk.sv
module rns_adder3_chk #(
    parameter int unsigned OPW  = 5,
    parameter int unsigned MOD0 = 3,
    parameter int unsigned MOD1 = 5,
    parameter int unsigned MOD2 = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [OPW-1:0]          op_a,
    input logic [OPW-1:0]          op_b,
    input logic                    out_valid,
    input logic [$clog2(MOD0)-1:0] sum_p0,
    input logic [$clog2(MOD1)-1:0] sum_p1,
    input logic [$clog2(MOD2)-1:0] sum_p2
);
    // R6
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_p0) && $stable(sum_p1) && $stable(sum_p2)));
    // R3
    mod3_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (32'(sum_p0) == (32'($past(op_a)) + 32'($past(op_b))) % MOD0));
    // R4
    mod5_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (32'(sum_p1) == (32'($past(op_a)) + 32'($past(op_b))) % MOD1));
    // R5
    mod7_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (32'(sum_p2) == (32'($past(op_a)) + 32'($past(op_b))) % MOD2));
    // R10
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sum_p0) < MOD0) && (32'(sum_p1) < MOD1) && (32'(sum_p2) < MOD2));
endmodule

bind rns_adder3 rns_adder3_chk #(
    .OPW(OPW), .MOD0(MOD0), .MOD1(MOD1), .MOD2(MOD2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .sum_p0    (sum_p0),
    .sum_p1    (sum_p1),
    .sum_p2    (sum_p2)
);

// File: tb/rns_adder3_test.sv
`timescale 1ns/100ps
module rns_adder3_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op_a = '0;
    logic [4:0] op_b = '0;
    logic       out_valid;
    logic [1:0] sum_p0;
    logic [2:0] sum_p1;
    logic [2:0] sum_p2;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rns_adder3 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .sum_p0(sum_p0), .sum_p1(sum_p1), .sum_p2(sum_p2)
    );

    // {a, b, exp mod3, exp mod5, exp mod7}
    localparam logic [17:0] VEC [9] = '{
        {5'd13, 5'd17, 2'd0, 3'd0, 3'd2},
        {5'd0,  5'd0,  2'd0, 3'd0, 3'd0},
        {5'd31, 5'd31, 2'd2, 3'd2, 3'd6},
        {5'd13, 5'd0,  2'd1, 3'd3, 3'd6},
        {5'd17, 5'd0,  2'd2, 3'd2, 3'd3},
        {5'd1,  5'd1,  2'd2, 3'd2, 3'd2},
        {5'd2,  5'd1,  2'd0, 3'd3, 3'd3},
        {5'd4,  5'd3,  2'd1, 3'd2, 3'd0},
        {5'd20, 5'd15, 2'd2, 3'd0, 3'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] a, input logic [4:0] b);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_sum(input string tag, input int a, input int b);
        chk({tag, " R6 valid"}, int'(out_valid), 1);
        chk({tag, " R3 mod3"}, int'(sum_p0), (a + b) % 3);
        chk({tag, " R4 mod5"}, int'(sum_p1), (a + b) % 5);
        chk({tag, " R5 mod7"}, int'(sum_p2), (a + b) % 7);
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(out_valid), 0);
        chk("R1 sums in reset", int'({sum_p0, sum_p1, sum_p2}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", int'(out_valid), 0);
        chk("R1 sums after reset", int'({sum_p0, sum_p1, sum_p2}), 0);

        // Table vectors: R2, R8, R9
        for (int i = 0; i < 9; i++) begin
            apply(VEC[i][17:13], VEC[i][12:8]);
            chk($sformatf("R8/R9/R2 vec%0d mod3", i), int'(sum_p0), int'(VEC[i][7:6]));
            chk($sformatf("R8/R9/R2 vec%0d mod5", i), int'(sum_p1), int'(VEC[i][5:3]));
            chk($sformatf("R8/R9/R2 vec%0d mod7", i), int'(sum_p2), int'(VEC[i][2:0]));
            chk("R6 valid pulse", int'(out_valid), 1);
            @(negedge clk);
            chk("R6 valid drops", int'(out_valid), 0);
        end

        // R7: operands change while strobe is low
        apply(5'd11, 5'd9);
        op_a = 5'd30; op_b = 5'd29;
        repeat (4) @(negedge clk);
        chk("R7 hold mod3", int'(sum_p0), 20 % 3);
        chk("R7 hold mod5", int'(sum_p1), 20 % 5);
        chk("R7 hold mod7", int'(sum_p2), 20 % 7);
        chk("R7 valid low", int'(out_valid), 0);

        // Full sweep, back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1;
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                op_a = 5'(a); op_b = 5'(b);
                @(negedge clk);
                check_sum("sweep", a, b);
                chk("R10 range", int'(sum_p0 < 3 && sum_p1 < 5 && sum_p2 < 7), 1);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R6 valid after sweep", int'(out_valid), 0);
        chk("R7 hold after sweep", int'(sum_p2), 62 % 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule